// File: doc/BRIEF.md
# Frequency Counter Gate Sequencer

This block produces the timing for a gated frequency counter from a crystal reference clock. A free-running divider turns the reference into a slow base tick. A tick counter then walks through one measurement cycle of a fixed length. The cycle always runs in the same order: the counting window, then a one-clock strobe that latches the result, then a short window in which the external counter is preset.

The measured signal arrives as an already synchronized pulse train. The block detects each rising edge of it. While the window is open, those edges feed a decade prescaler, and every tenth edge produces one count clock for the external digit counters. With the default values, a 16 MHz reference gives an 80 Hz tick and a 200 ms cycle. The counting window is then 100 ms and the preset window is 25 ms. Dividing by ten before gating gives 100 Hz per display count.

Top module: `fcgs_gate_seq`

## Requirements
- R1: While rst_ni is low, gate_o is 1 and preset_o, strobe_o and count_clk_o are 0. Reset starts a new cycle at the first reference clock of the counting window, with the prescaler at zero.
- R2: The base tick fires once every REF_DIV reference clocks. One measurement cycle lasts TICKS_PER_CYCLE ticks, so gate_o rises every TICKS_PER_CYCLE*REF_DIV clocks.
- R3: gate_o is high exactly during ticks 0 to GATE_TICKS-1 of each cycle.
- R4: strobe_o is high for exactly one reference clock. That clock is the first one after gate_o falls, which is the first clock of tick GATE_TICKS.
- R5: preset_o is high for PRESET_TICKS whole ticks, starting at tick GATE_TICKS+1.
- R6: At most one of gate_o, strobe_o and preset_o is high in any clock.
- R7: A rising edge of pulse_i is a 0-to-1 change between consecutive clocks. Counting from the start of a window, every PRESCALE-th rising edge seen while gate_o is high makes count_clk_o high for one clock, in the clock that follows that edge.
- R8: Rising edges of pulse_i while gate_o is low have no effect: count_clk_o stays 0 and the prescaler count is held.
- R9: The prescaler is cleared during preset_o. The number of count_clk_o pulses in a cycle therefore equals floor(gated edges / PRESCALE), and a remainder is never carried into the next cycle.
- R10: A pulse_i level held high for many clocks counts as a single edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pulse_i | input | 1 | Synchronized measured pulse train |
| gate_o | output | 1 | Counting window open |
| preset_o | output | 1 | Counter preset load window |
| strobe_o | output | 1 | Result register load strobe, one clock wide |
| count_clk_o | output | 1 | Gated, divided-by-ten count clock |

## Verification
The bench drives four stimulus patterns, each lasting one full cycle:
- Toggling every clock, which gives twenty edges per window.
- A sparse pattern that leaves a remainder in the prescaler. If the clear were missing, the next window would get an extra early count clock.
- A level held high. A design that counted levels instead of edges would emit a burst of count clocks.
- Short pulses that continue while the gate is closed. A design that did not gate the prescaler would leak count clocks outside the window.

A reset in the middle of a cycle checks that the sequence restarts at the counting window. An off-by-one in the tick decode would show up as a shifted or stretched gate, strobe or preset edge against the cycle model.

// File: rtl/fcgs_pkg.sv
package fcgs_pkg;
  typedef struct packed {
    logic gate;
    logic strobe;
    logic preset;
  } fcgs_ctl_t;
endpackage

// File: rtl/fcgs_ref_div.sv
module fcgs_ref_div #(
  parameter int unsigned DIV = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o,
  output logic first_o
);
  localparam int unsigned W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o  = (cnt_q == LAST);
  assign first_o = (cnt_q == '0);

  // R2: the count wraps to zero right after the tick
  assert_tick_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> first_o);
endmodule

// File: rtl/fcgs_phase_seq.sv
module fcgs_phase_seq
  import fcgs_pkg::*;
#(
  parameter int unsigned TICKS_PER_CYCLE = 16,
  parameter int unsigned GATE_TICKS      = 8,
  parameter int unsigned PRESET_TICKS    = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      first_i,
  output fcgs_ctl_t ctl_o
);
  localparam int unsigned TW         = $clog2(TICKS_PER_CYCLE);
  localparam int unsigned PRE_START  = GATE_TICKS + 1;
  localparam int unsigned PRE_END    = PRE_START + PRESET_TICKS;
  localparam logic [TW-1:0] LAST    = TW'(TICKS_PER_CYCLE - 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else if (tick_i) tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
  end

  always_comb begin
    ctl_o.gate   = 32'(tick_q) < GATE_TICKS;
    ctl_o.strobe = (32'(tick_q) == GATE_TICKS) && first_i;
    ctl_o.preset = (32'(tick_q) >= PRE_START) && (32'(tick_q) < PRE_END);
  end

  assert_tick_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tick_q) < TICKS_PER_CYCLE);
  assert_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctl_o.gate, ctl_o.strobe, ctl_o.preset}));
  assert_strobe_after_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_o.gate) |-> ctl_o.strobe);
  assert_strobe_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.strobe |=> !ctl_o.strobe);
endmodule

// File: rtl/fcgs_prescaler.sv
module fcgs_prescaler #(
  parameter int unsigned PRESCALE = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic gate_i,
  input  logic clr_i,
  output logic count_clk_o
);
  localparam int unsigned PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic          prev_q;
  logic [PW-1:0] div_q;
  logic          edge_ok;

  // R10: edge detect, a held level counts once
  assign edge_ok = pulse_i & ~prev_q & gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b0;
      div_q       <= '0;
      count_clk_o <= 1'b0;
    end else begin
      prev_q      <= pulse_i;
      count_clk_o <= edge_ok && (div_q == LAST);
      if (clr_i)        div_q <= '0;           // R9
      else if (edge_ok) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
    end
  end

  assert_clk_in_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_clk_o |-> $past(gate_i));
  assert_clk_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_clk_o |=> !count_clk_o);
  assert_clear_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0);
endmodule

// File: rtl/fcgs_gate_seq.sv
module fcgs_gate_seq
  import fcgs_pkg::*;
#(
  parameter int unsigned REF_DIV         = 200000,
  parameter int unsigned TICKS_PER_CYCLE = 16,
  parameter int unsigned GATE_TICKS      = 8,
  parameter int unsigned PRESET_TICKS    = 2,
  parameter int unsigned PRESCALE        = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic gate_o,
  output logic preset_o,
  output logic strobe_o,
  output logic count_clk_o
);
  logic      tick, first;
  fcgs_ctl_t ctl;

  fcgs_ref_div #(.DIV(REF_DIV)) u_ref_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .first_o(first)
  );

  fcgs_phase_seq #(
    .TICKS_PER_CYCLE(TICKS_PER_CYCLE),
    .GATE_TICKS(GATE_TICKS),
    .PRESET_TICKS(PRESET_TICKS)
  ) u_phase_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .first_i(first), .ctl_o(ctl)
  );

  fcgs_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i),
    .gate_i(ctl.gate), .clr_i(ctl.preset), .count_clk_o(count_clk_o)
  );

  assign gate_o   = ctl.gate;
  assign preset_o = ctl.preset;
  assign strobe_o = ctl.strobe;

  assert_preset_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_o |-> !count_clk_o);
  assert_reset_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> !count_clk_o && !strobe_o && !preset_o);
endmodule

// File: tb/tb_fcgs_gate_seq.sv
module tb_fcgs_gate_seq;
  localparam int REF_DIV = 5, TICKS = 16, GATE = 8, PRE = 2, PS = 10;
  localparam int CYCLE = REF_DIV * TICKS;

  logic clk = 1'b0, rst_n = 1'b0, pulse = 1'b0;
  logic gate_o, preset_o, strobe_o, count_clk_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fcgs_gate_seq #(.REF_DIV(REF_DIV), .TICKS_PER_CYCLE(TICKS), .GATE_TICKS(GATE),
                  .PRESET_TICKS(PRE), .PRESCALE(PS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .gate_o(gate_o),
    .preset_o(preset_o), .strobe_o(strobe_o), .count_clk_o(count_clk_o));

  // behavioural model state
  int ref_m = 0, tick_m = 0, pc_m = 0, prev_m = 0, cclk_m = 0;
  int edges_w = 0, clks_w = 0, since_rise = 0, step = 0;
  bit pre_prev = 0, gate_prev = 1, seen_rise = 0;

  function automatic bit m_gate();   return tick_m < GATE; endfunction
  function automatic bit m_strobe(); return tick_m == GATE && ref_m == 0; endfunction
  function automatic bit m_preset(); return tick_m >= GATE + 1 && tick_m < GATE + 1 + PRE; endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_m = 0; tick_m = 0; pc_m = 0; prev_m = 0; cclk_m = 0;
      edges_w = 0; clks_w = 0;
    end else begin
      bit e;
      e = pulse && !prev_m && m_gate();
      cclk_m = (e && pc_m == PS - 1) ? 1 : 0;
      if (e) edges_w++;
      if (m_preset()) pc_m = 0;
      else if (e) pc_m = (pc_m == PS - 1) ? 0 : pc_m + 1;
      prev_m = pulse;
      if (ref_m == REF_DIV - 1) begin
        ref_m = 0;
        tick_m = (tick_m == TICKS - 1) ? 0 : tick_m + 1;
      end else ref_m++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", gate_o, m_gate());
      chk("R4", strobe_o, m_strobe());
      chk("R5", preset_o, m_preset());
      chk(m_gate() || strobe_o ? "R7" : "R8", count_clk_o, cclk_m);
      chk("R6", int'(gate_o) + int'(strobe_o) + int'(preset_o) <= 1, 1);
      if (count_clk_o) clks_w++;
      if (m_preset() && !pre_prev) begin
        chk("R9", clks_w, edges_w / PS);
        clks_w = 0; edges_w = 0;
      end
      pre_prev = m_preset();
      since_rise++;
      if (gate_o && !gate_prev) begin
        if (seen_rise) chk("R2", since_rise, CYCLE);
        seen_rise = 1; since_rise = 0;
      end
      gate_prev = gate_o;
      // stimulus
      step++;
      case ((step / CYCLE) % 4)
        0: pulse <= ~pulse;
        1: pulse <= (step % 3 == 0);
        2: pulse <= 1'b1;                 // R10: held level
        default: pulse <= (step % 4 == 0);
      endcase
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", gate_o, 1); chk("R1", strobe_o, 0);
    chk("R1", preset_o, 0); chk("R1", count_clk_o, 0);
    rst_n = 1'b1;
    repeat (5 * CYCLE + 17) @(negedge clk);
    // R10: count_clk pulses in held-high window observed through R9 tallies
    rst_n = 1'b0; pulse = 1'b0;
    #1;
    chk("R1", gate_o, 1); chk("R1", strobe_o, 0);
    chk("R1", preset_o, 0); chk("R1", count_clk_o, 0);
    seen_rise = 0; gate_prev = 1; pre_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4 * CYCLE + 9) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule